// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block keeps one pending flag per interrupt line of a small processor core. One line is non-maskable and twelve are maskable. A flag goes to 1 when its line fires and stays at 1 until it is cleared. Software reaches the block through a single-port control-register interface. One index reads the flags; a write to the same index sets flags wherever the written word has a 1. A second index clears flags wherever the written word has a 1. Two more indices hold the per-line enables and a global enable bit.

The block combines the pending flags, the per-line enables and the global enable into one request. It presents the request with the index of the most urgent eligible line. The core acknowledges the line it takes by pulsing an acknowledge input with that line's index, and the flag drops on the next clock edge.

Line numbers map directly to bit positions of a 16-bit line vector. Bit 1 is the non-maskable line and bits 4 to 15 are the maskable lines. Bits 0, 2 and 3 are not implemented.

Top module: `irqc_top`

## Requirements
- R1: While reset is asserted and right after it is released, every flag, every per-line enable and the global enable are 0. `req_valid` is 0, and reads of indices 1, 2 and 4 return 0.
- R2: A 1 on `line_evt` bit 1 or on any bit 4..15 sets that flag at the next rising clock edge. The flag then holds at 1 until a clear or an acknowledge removes it. `line_evt` bits 0, 2 and 3 have no effect.
- R3: A write to index 2 sets flag bits 4..15 wherever the data has a 1. Bits with a 0 are unchanged. Data bits 0..3 have no effect, so the non-maskable flag cannot be set this way.
- R4: A write to index 3 clears flag bits 4..15 wherever the data has a 1. Bits with a 0 are unchanged. The non-maskable flag at bit 1 is not cleared by this write.
- R5: A read of index 2 returns the flags in bits 1 and 4..15 and 0 in every other bit. A read of index 4 returns the enables in the same positions. A read of index 1 returns the global enable in bit 0. Any other index reads as 0.
- R6: A write to index 4 loads the enables for bits 1 and 4..15 when `user_mode` is 0. When `user_mode` is 1, the write is ignored.
- R7: A write to index 1 loads the global enable from data bit 0, in either mode.
- R8: `req_valid` is 1 exactly when some flag is pending and its enable is set. For a maskable line the global enable must also be 1. The non-maskable line ignores the global enable.
- R9: `req_idx` gives the line number of the winner. The non-maskable line (1) wins first, then line 4, with line 15 last. `req_idx` is 0 when there is no request.
- R10: When `ack` is 1, the flag numbered by `ack_idx` clears at the next edge. All other flags are unaffected.
- R11: When a line fires in the same cycle as a clear write or an acknowledge of that line, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| line_evt | input | 16 | Interrupt line events, one bit per line number |
| user_mode | input | 1 | 1 when the core runs in user mode |
| creg_wr_en | input | 1 | Control-register write strobe |
| creg_idx | input | 5 | Control-register index for read and write |
| creg_wdata | input | 32 | Control-register write data |
| creg_rdata | output | 32 | Control-register read data for `creg_idx` |
| ack | input | 1 | Acknowledge of a taken line |
| ack_idx | input | 4 | Line number being acknowledged |
| req_valid | output | 1 | An eligible interrupt is pending |
| req_idx | output | 4 | Line number of the highest-priority eligible interrupt |

## Verification
Each corner case below is paired with the fault it would expose.

- The non-maskable flag is written through both software ports. A design that let the set or clear registers reach bit 1 would show a changed flag read-back.
- With the global enable off, a pending non-maskable line must still raise `req_valid`. A design that gated it would drop the request.
- A hardware event is raised in the same cycle as a clear and as an acknowledge of that line. A design that gave software priority would lose the event.
- An enable write is made in user mode, and a line other than the winner is acknowledged. These catch a design that ignores the mode input or clears the wrong flag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINE_W  = 16;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CIDX_W  = 5;
  localparam int unsigned IDX_W   = $clog2(LINE_W);
  localparam int unsigned NMI_POS = 1;
  localparam int unsigned MASK_LO = 4;

  localparam logic [CIDX_W-1:0] CI_STATUS  = CIDX_W'(1);
  localparam logic [CIDX_W-1:0] CI_FLAGSET = CIDX_W'(2);
  localparam logic [CIDX_W-1:0] CI_CLEAR   = CIDX_W'(3);
  localparam logic [CIDX_W-1:0] CI_ENABLE  = CIDX_W'(4);

  typedef logic [LINE_W-1:0] line_vec_t;

  // implemented line positions: the non-maskable bit plus MASK_LO..LINE_W-1
  function automatic line_vec_t impl_mask();
    line_vec_t m;
    m = '0;
    m[NMI_POS] = 1'b1;
    for (int i = MASK_LO; i < LINE_W; i++) m[i] = 1'b1;
    return m;
  endfunction

  // positions software may set or clear
  function automatic line_vec_t maskable_mask();
    line_vec_t m;
    m = impl_mask();
    m[NMI_POS] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              user_mode,
  output logic              gie_q,
  output line_vec_t         en_q
);
  localparam line_vec_t IMPL = impl_mask();

  logic      gie_ce, en_ce;
  logic      gie_d;
  line_vec_t en_d;

  always_comb begin
    gie_ce = wr_en && (wr_idx == CI_STATUS);
    en_ce  = wr_en && (wr_idx == CI_ENABLE) && !user_mode;
    gie_d  = wr_data[0];
    en_d   = wr_data[LINE_W-1:0] & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_ce) begin
      gie_q <= gie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t evt,
  input  line_vec_t set_vec,
  input  line_vec_t clr_vec,
  input  line_vec_t ack_vec,
  output line_vec_t flag_q
);
  localparam line_vec_t IMPL = impl_mask();

  for (genvar i = 0; i < LINE_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      logic bit_d;
      // a hardware event overrides any clear or acknowledge in the same cycle
      always_comb begin
        bit_d = evt[i] | set_vec[i] | (flag_q[i] & ~clr_vec[i] & ~ack_vec[i]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[i] <= 1'b0;
        end else begin
          flag_q[i] <= bit_d;
        end
      end
    end else begin : g_none
      assign flag_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
  import irqc_pkg::*;
(
  input  line_vec_t        elig,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);
  always_comb begin
    pick_valid = |elig;
    pick_idx   = '0;
    for (int i = LINE_W - 1; i >= int'(MASK_LO); i--) begin
      if (elig[i]) pick_idx = IDX_W'(i);
    end
    if (elig[NMI_POS]) pick_idx = IDX_W'(NMI_POS);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       line_evt,
  input  logic              user_mode,
  input  logic              creg_wr_en,
  input  logic [4:0]        creg_idx,
  input  logic [31:0]       creg_wdata,
  output logic [31:0]       creg_rdata,
  input  logic              ack,
  input  logic [3:0]        ack_idx,
  output logic              req_valid,
  output logic [3:0]        req_idx
);
  localparam line_vec_t IMPL     = impl_mask();
  localparam line_vec_t MASKABLE = maskable_mask();
  localparam line_vec_t NMI_ONLY = line_vec_t'(1) << NMI_POS;

  logic      gie_q;
  line_vec_t en_q;
  line_vec_t flag_q;
  line_vec_t evt_vec, set_vec, clr_vec, ack_vec, elig;

  always_comb begin
    evt_vec = line_evt & IMPL;
    set_vec = (creg_wr_en && creg_idx == CI_FLAGSET) ? (creg_wdata[LINE_W-1:0] & MASKABLE) : '0;
    clr_vec = (creg_wr_en && creg_idx == CI_CLEAR)   ? (creg_wdata[LINE_W-1:0] & MASKABLE) : '0;
    ack_vec = ack ? ((line_vec_t'(1) << ack_idx) & IMPL) : '0;
    elig    = flag_q & en_q & (gie_q ? IMPL : NMI_ONLY);
  end

  irqc_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (creg_wr_en),
    .wr_idx    (creg_idx),
    .wr_data   (creg_wdata),
    .user_mode (user_mode),
    .gie_q     (gie_q),
    .en_q      (en_q)
  );

  irqc_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_vec),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .ack_vec (ack_vec),
    .flag_q  (flag_q)
  );

  irqc_prio_pick u_pick (
    .elig       (elig),
    .pick_valid (req_valid),
    .pick_idx   (req_idx)
  );

  always_comb begin
    unique case (creg_idx)
      CI_STATUS:  creg_rdata = {{(DATA_W-1){1'b0}}, gie_q};
      CI_FLAGSET: creg_rdata = {{(DATA_W-LINE_W){1'b0}}, flag_q};
      CI_ENABLE:  creg_rdata = {{(DATA_W-LINE_W){1'b0}}, en_q};
      default:    creg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] line_evt,
  input logic        user_mode,
  input logic        creg_wr_en,
  input logic [4:0]  creg_idx,
  input logic        ack,
  input logic [3:0]  ack_idx,
  input logic        req_valid,
  input logic [3:0]  req_idx,
  input logic [15:0] flag_q,
  input logic [15:0] en_q,
  input logic        gie_q
);
  localparam line_vec_t IMPL = impl_mask();

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(line_evt & IMPL)) == $past(line_evt & IMPL)));

  p_nmi_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (creg_wr_en && creg_idx == CI_CLEAR && flag_q[NMI_POS] && !ack) |=> flag_q[NMI_POS]);

  p_user_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (creg_wr_en && creg_idx == CI_ENABLE && user_mode) |=> $stable(en_q));

  p_req_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !(flag_q[NMI_POS] && en_q[NMI_POS])) |-> !req_valid);

  p_req_real_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (flag_q[req_idx] && en_q[req_idx]));

  p_nmi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[NMI_POS] && en_q[NMI_POS]) |-> (req_valid && req_idx == 4'(NMI_POS)));

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && IMPL[ack_idx] && !line_evt[ack_idx] &&
     !(creg_wr_en && creg_idx == CI_FLAGSET)) |=> !flag_q[$past(ack_idx)]);
endmodule

bind irqc_top irqc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_evt   (line_evt),
  .user_mode  (user_mode),
  .creg_wr_en (creg_wr_en),
  .creg_idx   (creg_idx),
  .ack        (ack),
  .ack_idx    (ack_idx),
  .req_valid  (req_valid),
  .req_idx    (req_idx),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .gie_q      (gie_q)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] line_evt;
  logic        user_mode;
  logic        creg_wr_en;
  logic [4:0]  creg_idx;
  logic [31:0] creg_wdata;
  logic [31:0] creg_rdata;
  logic        ack;
  logic [3:0]  ack_idx;
  logic        req_valid;
  logic [3:0]  req_idx;

  int checks = 0;
  int fails  = 0;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .line_evt(line_evt), .user_mode(user_mode),
    .creg_wr_en(creg_wr_en), .creg_idx(creg_idx), .creg_wdata(creg_wdata),
    .creg_rdata(creg_rdata), .ack(ack), .ack_idx(ack_idx),
    .req_valid(req_valid), .req_idx(req_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // op: 0 idle, 1 register write, 2 line event, 3 acknowledge
  typedef struct packed {
    logic [1:0]  op;
    logic        usr;
    logic [4:0]  idx;
    logic [15:0] dat;
    logic [15:0] fl;
    logic        vld;
    logic [3:0]  ri;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{2'd1, 1'b0, 5'd1, 16'h0001, 16'h0000, 1'b0, 4'd0},   // R7 global on
    '{2'd1, 1'b0, 5'd4, 16'hFFFF, 16'h0000, 1'b0, 4'd0},   // R6 all enables
    '{2'd2, 1'b0, 5'd0, 16'h0100, 16'h0100, 1'b1, 4'd8},   // R2 line 8
    '{2'd1, 1'b0, 5'd2, 16'h0030, 16'h0130, 1'b1, 4'd4},   // R3 set 4,5
    '{2'd1, 1'b0, 5'd2, 16'h000F, 16'h0130, 1'b1, 4'd4},   // R3 low bits ignored
    '{2'd1, 1'b0, 5'd3, 16'h0010, 16'h0120, 1'b1, 4'd5},   // R4 clear 4
    '{2'd2, 1'b0, 5'd0, 16'h0002, 16'h0122, 1'b1, 4'd1},   // R9 NMI first
    '{2'd1, 1'b0, 5'd3, 16'h0002, 16'h0122, 1'b1, 4'd1},   // R4 NMI not cleared
    '{2'd3, 1'b0, 5'd0, 16'h0001, 16'h0120, 1'b1, 4'd5},   // R10 ack NMI
    '{2'd1, 1'b0, 5'd1, 16'h0000, 16'h0120, 1'b0, 4'd0},   // R8 global off
    '{2'd2, 1'b0, 5'd0, 16'h0002, 16'h0122, 1'b1, 4'd1},   // R8 NMI ignores global
    '{2'd3, 1'b0, 5'd0, 16'h0001, 16'h0120, 1'b0, 4'd0},   // R10
    '{2'd1, 1'b0, 5'd1, 16'h0001, 16'h0120, 1'b1, 4'd5},   // R7
    '{2'd1, 1'b1, 5'd4, 16'h0000, 16'h0120, 1'b1, 4'd5},   // R6 user write ignored
    '{2'd1, 1'b0, 5'd4, 16'h0100, 16'h0120, 1'b1, 4'd8},   // R6 enable only 8
    '{2'd1, 1'b0, 5'd3, 16'hFFFF, 16'h0000, 1'b0, 4'd0},   // R4 clear all
    '{2'd2, 1'b0, 5'd0, 16'h800D, 16'h8000, 1'b0, 4'd0},   // R2 bits 0,2,3 ignored
    '{2'd1, 1'b0, 5'd4, 16'hFFFF, 16'h8000, 1'b1, 4'd15}   // R8 line 15
  };

  task automatic idle_inputs();
    line_evt = '0; creg_wr_en = 1'b0; creg_wdata = '0; ack = 1'b0; ack_idx = '0;
    user_mode = 1'b0; creg_idx = 5'd2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic [4:0] idx, input logic [31:0] exp);
    creg_idx = idx;
    #1;
    check(req, creg_rdata, exp);
    creg_idx = 5'd2;
  endtask

  // apply stimulus for one edge, return to idle, then sample
  task automatic one_cycle();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    read_chk("R1 flags", 5'd2, 32'h0);
    read_chk("R1 enables", 5'd4, 32'h0);
    read_chk("R1 global", 5'd1, 32'h0);
    check("R1 req_valid", {31'b0, req_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    read_chk("R1 flags after release", 5'd2, 32'h0);

    for (int v = 0; v < NV; v++) begin
      unique case (VT[v].op)
        2'd1: begin
          creg_wr_en = 1'b1; creg_idx = VT[v].idx;
          creg_wdata = {16'h0, VT[v].dat}; user_mode = VT[v].usr;
        end
        2'd2: line_evt = VT[v].dat;
        2'd3: begin ack = 1'b1; ack_idx = VT[v].dat[3:0]; end
        default: ;
      endcase
      one_cycle();
      check($sformatf("R5 table %0d flags", v), creg_rdata, {16'h0, VT[v].fl});
      check($sformatf("R8 table %0d request", v), {27'b0, req_valid, req_idx},
            {27'b0, VT[v].vld, VT[v].ri});
    end

    // R5 R7 R6 read back of configuration
    read_chk("R7 global readback", 5'd1, 32'h1);
    read_chk("R6 enables readback", 5'd4, 32'h0000FFF2);
    read_chk("R5 unused index", 5'd9, 32'h0);

    // R11 event beats clear
    creg_wr_en = 1'b1; creg_idx = 5'd3; creg_wdata = 32'h8000; line_evt = 16'h8000;
    one_cycle();
    check("R11 event vs clear", creg_rdata, 32'h8000);

    // R11 event beats ack
    ack = 1'b1; ack_idx = 4'd15; line_evt = 16'h8000;
    one_cycle();
    check("R11 event vs ack", creg_rdata, 32'h8000);

    // R10 ack of a non-winning line clears only that line
    creg_wr_en = 1'b1; creg_idx = 5'd2; creg_wdata = 32'h0210;
    one_cycle();
    check("R3 set 4,9", creg_rdata, 32'h8210);
    ack = 1'b1; ack_idx = 4'd9;
    one_cycle();
    check("R10 ack line 9", creg_rdata, 32'h8010);
    check("R9 winner line 4", {27'b0, req_valid, req_idx}, {27'b0, 1'b1, 4'd4});

    // R2 flags hold while idle
    repeat (5) one_cycle();
    check("R2 hold", creg_rdata, 32'h8010);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule